// File: doc/BRIEF.md
# Address-Range Cache Maintenance Engine

This block sits beside a shared last-level cache. Software uses it to clean, invalidate, or clean-and-invalidate every line that overlaps a window of physical addresses. It has three 64-bit registers on a simple register bus: a window base, a window limit and a command word. Software writes the base and the limit. It then writes the command word, which starts the walk. From then on the engine sends one maintenance request per cache line on a valid/ready port.

Software learns that the walk has finished by polling the busy bit in the command word. Hardware clears that bit when every covered line has been accepted downstream. Writes that arrive while a walk is running are dropped and raise a sticky error bit, so a driver can detect a programming race.

Top module: `cme_engine`

## Requirements
- R1: Registers are decoded on the full bus offset: base at 0x00, limit at 0x08, command at 0x10. Reads of base and limit return the stored 40-bit address zero-extended to 64 bits. Reads at any other offset return zero.
- R2: Bits 63:40 of a write to the base or limit register are discarded, and only bits 39:0 are stored.
- R3: A write to the command register while idle starts a walk whatever value bit 0 carries. Bit 0 of the command register reads 1 from the cycle after that write until the walk completes.
- R4: The walk issues line indices (address bits 39:6) in ascending order. It starts at the base rounded down to a 64-byte boundary and emits every line whose base address is strictly below the limit, so partly covered first and last lines are included.
- R5: Command bits 2:1 select the operation and are presented unchanged on the request mode output for every line: 0 = clean and invalidate, 1 = invalidate without write-back, 2 = clean keeping lines valid.
- R6: While a request is valid and not accepted, its line index and mode stay unchanged. The index advances only on a cycle with valid and ready both high.
- R7: Busy stays high for exactly one cycle after the last accepted line. With N lines and S stall cycles (valid high, ready low), busy is observed high for N+S+1 cycles.
- R8: If the limit is less than or equal to the base, no request is issued and busy is high for exactly one cycle.
- R9: While busy, any register write is ignored and sets command bit 3. Bit 3 stays set until software writes the command register with bit 3 = 1 while idle.
- R10: Asserting the active-low reset clears all registers, forces busy low and removes any pending request at once.
- R11: A window that reaches the top of the 40-bit space ends after its last line and does not wrap to line zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Register byte offset, used for both reads and writes |
| bus_wdata | input | 64 | Register write data |
| bus_rdata | output | 64 | Combinational read data for bus_addr |
| req_valid | output | 1 | Per-line maintenance request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_line | output | 34 | Line index (physical address bits 39:6) |
| req_mode | output | 2 | Operation code for the request |

## Verification
A command write sampled at edge k makes busy readable at the next falling edge. The first request appears in that same cycle. The bench drives and samples at falling edges, so each line index is compared in the cycle it is presented. Each handshake happens at the following rising edge, and busy clears one edge after the last one. The bench counts stalls it creates with randomly withheld ready and checks the busy length against lines plus stalls plus one. Register reads are combinational and are sampled 1 ns after the address changes.

// File: rtl/cme_pkg.sv
package cme_pkg;
  typedef enum logic [1:0] {
    OP_CLEAN_INV = 2'd0,
    OP_INV       = 2'd1,
    OP_CLEAN     = 2'd2,
    OP_RSVD      = 2'd3
  } cme_op_e;

  localparam int OFS_BASE  = 'h00;
  localparam int OFS_LIMIT = 'h08;
  localparam int OFS_CMD   = 'h10;

  localparam int BUSY_BIT = 0;
  localparam int MODE_LSB = 1;
  localparam int ERR_BIT  = 3;
endpackage

// File: rtl/cme_regs.sv
module cme_regs
  import cme_pkg::*;
#(
  parameter int PA_W   = 40,
  parameter int BUS_AW = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PA_W-1:0]   base_addr,
  output logic [PA_W-1:0]   limit_addr,
  output cme_op_e           mode,
  output logic              go
);
  logic hit_base, hit_limit, hit_cmd;
  logic [PA_W-1:0] base_q, base_d, limit_q, limit_d;
  cme_op_e mode_q, mode_d;
  logic err_q, err_d;
  logic reg_en;
  logic unused_wdata;

  assign hit_base  = (bus_addr == BUS_AW'(OFS_BASE));
  assign hit_limit = (bus_addr == BUS_AW'(OFS_LIMIT));
  assign hit_cmd   = (bus_addr == BUS_AW'(OFS_CMD));
  assign reg_en    = bus_wr;
  assign unused_wdata = ^{bus_wdata[DATA_W-1:PA_W], bus_wdata[BUSY_BIT]};

  always_comb begin
    base_d  = base_q;
    limit_d = limit_q;
    mode_d  = mode_q;
    err_d   = err_q;
    go      = 1'b0;
    if (bus_wr) begin
      if (busy) begin
        err_d = 1'b1;
      end else begin
        if (hit_base)  base_d  = bus_wdata[PA_W-1:0];
        if (hit_limit) limit_d = bus_wdata[PA_W-1:0];
        if (hit_cmd) begin
          mode_d = cme_op_e'(bus_wdata[MODE_LSB +: 2]);
          go     = 1'b1;
          if (bus_wdata[ERR_BIT]) err_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      mode_q  <= OP_CLEAN_INV;
      err_q   <= 1'b0;
    end else if (reg_en) begin
      base_q  <= base_d;
      limit_q <= limit_d;
      mode_q  <= mode_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_base)  bus_rdata[PA_W-1:0] = base_q;
    if (hit_limit) bus_rdata[PA_W-1:0] = limit_q;
    if (hit_cmd) begin
      bus_rdata[BUSY_BIT]     = busy;
      bus_rdata[MODE_LSB +: 2] = mode_q;
      bus_rdata[ERR_BIT]      = err_q;
    end
  end

  assign base_addr  = base_q;
  assign limit_addr = limit_q;
  assign mode       = mode_q;

  // R9: a write during a walk must leave the error flag set
  assert_busy_write_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && busy |=> err_q);

  // R9: programmed window and operation stay frozen during a walk
  assert_regs_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q) && $stable(limit_q) && $stable(mode_q));
endmodule

// File: rtl/cme_walker.sv
module cme_walker #(
  parameter int PA_W       = 40,
  parameter int LINE_BYTES = 64
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   go,
  input  logic [PA_W-1:0]                        base_addr,
  input  logic [PA_W-1:0]                        limit_addr,
  input  logic                                   req_ready,
  output logic                                   busy,
  output logic                                   req_valid,
  output logic [PA_W-$clog2(LINE_BYTES)-1:0]     req_line
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = PA_W - OFF_W;
  localparam int CNT_W  = LINE_W + 1;

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] line_q, line_d;
  logic [PA_W-1:0]  lim_q, lim_d;
  logic [PA_W:0]    cur_base;
  logic             more, fire, walk_en;

  assign cur_base  = {line_q, {OFF_W{1'b0}}};
  assign more      = busy_q && (cur_base < {1'b0, lim_q});
  assign fire      = more && req_ready;
  assign walk_en   = go || busy_q;

  always_comb begin
    busy_d = busy_q;
    line_d = line_q;
    lim_d  = lim_q;
    if (go) begin
      busy_d = 1'b1;
      line_d = {1'b0, base_addr[PA_W-1:OFF_W]};
      lim_d  = (limit_addr > base_addr) ? limit_addr : '0;
    end else if (busy_q) begin
      if (fire)       line_d = line_q + 1'b1;
      else if (!more) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      line_q <= '0;
      lim_q  <= '0;
    end else if (walk_en) begin
      busy_q <= busy_d;
      line_q <= line_d;
      lim_q  <= lim_d;
    end
  end

  assign busy      = busy_q;
  assign req_valid = more;
  assign req_line  = line_q[LINE_W-1:0];

  // R6: stalled request holds its line index
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_line));

  // R3: requests only appear inside a busy window
  assert_req_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  // R3: a start always raises busy on the next cycle
  assert_go_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  // R7: busy only falls after a cycle with nothing pending
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(req_valid));

  // R8: an empty window never produces a request
  assert_empty_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go && (limit_addr <= base_addr) |=> !req_valid);
endmodule

// File: rtl/cme_engine.sv
module cme_engine
  import cme_pkg::*;
#(
  parameter int PA_W       = 40,
  parameter int LINE_BYTES = 64,
  parameter int BUS_AW     = 8,
  parameter int DATA_W     = 64,
  localparam int LINE_W    = PA_W - $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [LINE_W-1:0] req_line,
  output logic [1:0]        req_mode
);
  logic [PA_W-1:0] base_addr, limit_addr;
  cme_op_e         mode;
  logic            go, busy;

  cme_regs #(.PA_W(PA_W), .BUS_AW(BUS_AW), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .bus_rdata(bus_rdata),
    .base_addr(base_addr), .limit_addr(limit_addr), .mode(mode), .go(go)
  );

  cme_walker #(.PA_W(PA_W), .LINE_BYTES(LINE_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .base_addr(base_addr),
    .limit_addr(limit_addr), .req_ready(req_ready), .busy(busy),
    .req_valid(req_valid), .req_line(req_line)
  );

  assign req_mode = mode;

  // R5: mode on the request port stays put while a request is stalled
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_mode));
endmodule

// File: tb/tb_cme_engine.sv
module tb_cme_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [33:0] req_line;
  logic [1:0]  req_mode;

  int n_chk = 0;
  int n_err = 0;

  cme_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_line(req_line), .req_mode(req_mode)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic longint unsigned exp_lines(input logic [39:0] s, input logic [39:0] e);
    if (e <= s) return 0;
    return longint'((e - 40'd1) >> 6) - longint'(s >> 6) + 1;
  endfunction

  // Follows a walk from the cycle after the start edge until busy drops.
  task automatic walk(input logic [39:0] s, input logic [39:0] e, input logic [1:0] m,
                      input int stall_pct, input bit timing, input string tag);
    longint unsigned nexp = exp_lines(s, e);
    longint unsigned got = 0;
    longint unsigned stalls = 0;
    longint unsigned busyc = 0;
    logic [34:0] nxt = {1'b0, s[39:6]};
    bit held = 0;
    logic [33:0] held_line = '0;
    bit line_ok = 1;
    logic [33:0] bad_act = '0;
    logic [33:0] bad_exp = '0;
    bit stall_ok = 1;
    bit mode_ok = 1;
    bus_addr = 8'h10;
    forever begin
      @(negedge clk);
      #1;
      if (!bus_rdata[0]) break;
      busyc++;
      if (req_valid) begin
        if (got >= nexp || req_line != nxt[33:0]) begin
          if (line_ok) begin bad_act = req_line; bad_exp = nxt[33:0]; end
          line_ok = 0;
        end
        if (held && req_line != held_line) stall_ok = 0;
        if (req_mode != m) mode_ok = 0;
        req_ready = ($urandom_range(99) >= stall_pct);
        if (req_ready) begin got++; nxt = nxt + 35'd1; held = 0; end
        else begin stalls++; held = 1; held_line = req_line; end
      end else begin
        req_ready = $urandom_range(1);
      end
      if (busyc > 5000) break;
    end
    chk(line_ok, {tag, " R4 line order"}, 64'(bad_act), 64'(bad_exp));
    chk(got == nexp, {tag, " R4 R8 line count"}, got, nexp);
    chk(mode_ok, {tag, " R5 request mode"}, 64'(req_mode), 64'(m));
    chk(stall_ok, {tag, " R6 hold while stalled"}, 64'(req_line), 64'(held_line));
    if (timing) chk(busyc == nexp + stalls + 1, {tag, " R7 busy length"}, busyc, nexp + stalls + 1);
  endtask

  task automatic run_op(input logic [39:0] s, input logic [39:0] e, input logic [1:0] m,
                        input int stall_pct, input string tag);
    reg_wr(8'h00, {24'($urandom), s});
    reg_wr(8'h08, {24'($urandom), e});
    reg_wr(8'h10, {59'd0, 1'b0, 1'b0, m, 1'($urandom)});
    walk(s, e, m, stall_pct, 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; req_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: reset state
    reg_rd(8'h10, rd); chk(rd == 64'd0, "R10 command after reset", rd, 64'd0);
    reg_rd(8'h00, rd); chk(rd == 64'd0, "R10 base after reset", rd, 64'd0);
    chk(req_valid == 1'b0, "R10 no request after reset", 64'(req_valid), 64'd0);

    // R1, R2: readback, masking, unmapped offsets
    reg_wr(8'h00, 64'hDEAD_00AB_CDEF_1234);
    reg_rd(8'h00, rd); chk(rd == 64'h0000_00AB_CDEF_1234, "R1 R2 base readback", rd, 64'h0000_00AB_CDEF_1234);
    reg_wr(8'h08, 64'hFFFF_FF12_3456_7890);
    reg_rd(8'h08, rd); chk(rd == 64'h0000_0012_3456_7890, "R1 R2 limit readback", rd, 64'h0000_0012_3456_7890);
    reg_rd(8'h18, rd); chk(rd == 64'd0, "R1 unmapped 0x18", rd, 64'd0);
    reg_rd(8'h04, rd); chk(rd == 64'd0, "R1 unmapped 0x04", rd, 64'd0);

    // R3: start with bit 0 clear, busy visible
    req_ready = 1'b0;
    reg_wr(8'h00, 64'h1000);
    reg_wr(8'h08, 64'h1100);
    reg_wr(8'h10, 64'h4);
    reg_rd(8'h10, rd); chk(rd[0] == 1'b1, "R3 busy after start with bit0=0", 64'(rd[0]), 64'd1);
    chk(rd[2:1] == 2'd2, "R5 mode field readback", 64'(rd[2:1]), 64'd2);

    // R9: write during busy ignored, error set
    reg_wr(8'h00, 64'h7777_7777);
    reg_rd(8'h00, rd); chk(rd == 64'h1000, "R9 base unchanged by busy write", rd, 64'h1000);
    reg_rd(8'h10, rd); chk(rd[3] == 1'b1, "R9 error bit set", 64'(rd[3]), 64'd1);
    walk(40'h1000, 40'h1100, 2'd2, 30, 1'b0, "R9 walk");
    reg_rd(8'h10, rd); chk(rd[3] == 1'b1, "R9 error bit sticky", 64'(rd[3]), 64'd1);
    reg_wr(8'h08, 64'h1000);
    reg_wr(8'h10, 64'h8);
    walk(40'h1000, 40'h1000, 2'd0, 0, 1'b1, "R8 R9 clear");
    reg_rd(8'h10, rd); chk(rd[3] == 1'b0, "R9 error bit cleared", 64'(rd[3]), 64'd0);

    // Directed corners
    run_op(40'h2000, 40'h2040, 2'd0, 0, "R4 single full line");
    run_op(40'h203F, 40'h2041, 2'd1, 0, "R4 straddle two lines");
    run_op(40'h2047, 40'h2045, 2'd2, 0, "R8 limit below base");
    run_op(40'h3010, 40'h3010, 2'd0, 0, "R8 equal");
    run_op(40'h3001, 40'h3200, 2'd1, 50, "R6 heavy stall");
    run_op(40'hFF_FFFF_FFC0, 40'hFF_FFFF_FFFF, 2'd2, 0, "R11 top of space");
    run_op(40'hFF_FFFF_FF00, 40'hFF_FFFF_FFFF, 2'd0, 20, "R11 top four lines");

    // Random windows
    for (int i = 0; i < 40; i++) begin
      logic [39:0] s, e;
      s = 40'($urandom_range(32'h000F_FFFF)) << 8 | 40'($urandom_range(255));
      if ($urandom_range(9) == 0) e = s - 40'($urandom_range(100));
      else e = s + 40'($urandom_range(400));
      run_op(s, e, 2'($urandom_range(2)), int'($urandom_range(40)), "rand R4 R5 R7");
    end

    // R10: reset mid-walk
    req_ready = 1'b0;
    reg_wr(8'h00, 64'h5000);
    reg_wr(8'h08, 64'h6000);
    reg_wr(8'h10, 64'h2);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk(req_valid == 1'b0, "R10 request dropped by reset", 64'(req_valid), 64'd0);
    bus_addr = 8'h10; #1;
    chk(bus_rdata == 64'd0, "R10 command cleared by reset", bus_rdata, 64'd0);
    bus_addr = 8'h08; #1;
    chk(bus_rdata == 64'd0, "R10 limit cleared by reset", bus_rdata, 64'd0);
    @(negedge clk) rst_n = 1'b1;
    req_ready = 1'b1;
    run_op(40'h80, 40'h100, 2'd1, 0, "R3 walk after reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule